// File: doc/BRIEF.md
# Serial Configuration Slave with Status Readback

This block is a two-wire serial slave for fast-mode buses. It sits in front of a bank of control registers that can only be written and one status byte that can only be read. Writing works like this: the master sends the write address. The first byte after it selects a register index, and each later byte lands in the next index up. Reading works differently. A read takes no index phase: the master sends the read address straight after a Start, and the slave at once shifts out the byte present on `status_i`.

Both bus lines first pass through a digital deglitcher that samples them with the system clock. A bus edge only counts after the new level has held for `FILT_CYCLES` samples. An `enable` input comes from supply monitoring. While `enable` is low, the slave stays off the bus and its registers hold their default values.

The byte engine is one state machine with these states:
- `ST_IDLE`: wait for Start.
- `ST_ADDR`: shift in the address byte.
- `ST_ADDR_ACK`: acknowledge the address.
- `ST_SUB`: shift in the index.
- `ST_SUB_ACK`: acknowledge the index.
- `ST_DATA`: shift in a data byte.
- `ST_DATA_ACK`: acknowledge the data and write it.
- `ST_TX`: drive the status bits.
- `ST_TX_ACK`: sample the master's acknowledge.
- `ST_SKIP`: stay off the bus until the next Start or Stop.

The transitions are:
- A Start leads from any state to `ST_ADDR`. A Stop leads from any state to `ST_IDLE`.
- After eight address bits, `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches and to `ST_SKIP` when it does not.
- After the acknowledge, `ST_ADDR_ACK` goes to `ST_TX` for a read and to `ST_SUB` for a write.
- `ST_SUB` goes to `ST_SUB_ACK`, then on to `ST_DATA`.
- `ST_DATA` and `ST_DATA_ACK` alternate.
- `ST_TX` goes to `ST_TX_ACK`. From there the slave returns to `ST_TX` on a master ACK and goes to `ST_SKIP` on a NAK.
- Whenever `enable` is low, the machine is held in `ST_IDLE`.

Top module: `sercfg_slave`

## Requirements
- R1: The slave acknowledges only the address bytes 0x8C (write) and 0x8D (read). A byte is sent MSB first, and its bit 0 is the direction bit, 1 meaning read. Any other address byte gets no acknowledge, and the rest of that message has no effect on registers or SDA.
- R2: A pulse on SCL or SDA that lasts fewer than `FILT_CYCLES` clock cycles (default 6, or 60 ns at 100 MHz) is ignored. It creates no bit, no Start and no Stop.
- R3: In a write message, the first byte after the address is the register index. Every following byte is written to the current index, and the index then increments by one. The slave acknowledges every byte.
- R4: A repeated Start inside a message is accepted. A new write address followed by a new index restarts the writes at that index.
- R5: A read message returns the `status_i` value, MSB first. The value is captured at the SCL fall that ends the address acknowledge. After a master ACK, a fresh `status_i` value is captured and sent. After a NAK, SDA stays released until the next Start or Stop.
- R6: A write to an index of `NUM_REGS` or above is acknowledged and changes no register.
- R7: While `enable` is low, the slave gives no acknowledge. From the cycle after `enable` is seen low, SDA is released and all registers hold their defaults. SCL is never driven low.
- R8: After reset, register i holds `REG_DEFAULT + i` (modulo 256). The default `REG_DEFAULT` is 0x40.
- R9: While enabled, the slave changes its SDA drive only while the filtered SCL is low.
- R10: While enabled, at most one register changes in any clock cycle.
- R11: Register contents are never returned. A read that follows an index write through a repeated Start still returns the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the line sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High while the supply is in the normal range; low silences and clears the slave |
| scl_i | input | 1 | Level sensed on the SCL line |
| sda_i | input | 1 | Level sensed on the SDA line |
| status_i | input | 8 | Byte returned by a read message |
| scl_low_o | output | 1 | Open-drain pull-down request for SCL (never asserted) |
| sda_low_o | output | 1 | Open-drain pull-down request for SDA |
| regs_o | output | NUM_REGS*8 | Control register contents, register i in bits [8i+7:8i] |

## Verification
The assertions check four behaviours on every cycle:
- SDA is released, and the registers return to their defaults, one cycle after `enable` falls.
- The SDA drive never changes while the filtered SCL is high.
- At most one register changes per cycle.

Only the bench scenarios can show the rest:
- Address matching and rejection, with a sweep of every single-bit corruption of both addresses.
- The index auto-increment and the discard of writes beyond the last register.
- Repeated-Start index changes.
- Multi-byte status reads with a changing status input.
- The rejection of short pulses on either line in the middle of a byte.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_SKIP
    } slv_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/sercfg_deglitch.sv
// Two-flop synchroniser per line followed by a stability counter:
// a new level is accepted once it has been seen for STABLE_CYCLES samples.
module sercfg_deglitch #(
    parameter int STABLE_CYCLES = 6,
    parameter int LINES         = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] clean_o
);
    localparam int CW = $clog2(STABLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STABLE_CYCLES - 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [1:0]    sync_q;
        logic [CW-1:0] cnt_q;
        logic          lvl_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q <= 2'b11;
                cnt_q  <= '0;
                lvl_q  <= 1'b1;
            end else begin
                sync_q <= {sync_q[0], raw_i[g]};
                if (sync_q[1] == lvl_q) begin
                    cnt_q <= '0;
                end else if (cnt_q == LAST) begin
                    lvl_q <= sync_q[1];
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end

        assign clean_o[g] = lvl_q;
    end

endmodule

// File: rtl/sercfg_events.sv
// Bus events from the filtered lines: SCL edges, Start and Stop.
module sercfg_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign scl_rise  =  scl_f && !scl_q;
    assign scl_fall  = !scl_f &&  scl_q;
    assign bus_start =  scl_f &&  scl_q &&  sda_q && !sda_f;
    assign bus_stop  =  scl_f &&  scl_q && !sda_q &&  sda_f;

endmodule

// File: rtl/sercfg_regfile.sv
// Write-only control registers; synchronous return to defaults on clear.
module sercfg_regfile #(
    parameter int          NUM_REGS    = 8,
    parameter logic [7:0]  REG_DEFAULT = 8'h40
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [7:0]            wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] regs_o
);
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [7:0] DFLT = REG_DEFAULT + 8'(g);
        logic [7:0] val_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= DFLT;
            end else if (clear) begin
                val_q <= DFLT;
            end else if (wr_en && wr_idx == 8'(g)) begin
                val_q <= wr_data;
            end
        end

        assign regs_o[g*8 +: 8] = val_q;
    end

endmodule

// File: rtl/sercfg_slave.sv
module sercfg_slave
    import sercfg_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] REG_DEFAULT = 8'h40,
    parameter logic [6:0] DEV_ADDR    = 7'h46,
    parameter int         FILT_CYCLES = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  enable,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic [7:0]            status_i,
    output logic                  scl_low_o,
    output logic                  sda_low_o,
    output logic [NUM_REGS*8-1:0] regs_o
);
    localparam logic [3:0] FULL = 4'(BYTE_BITS);

    logic [1:0] clean;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, bus_start, bus_stop;

    sercfg_deglitch #(.STABLE_CYCLES(FILT_CYCLES), .LINES(2)) u_filt (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_i   ({scl_i, sda_i}),
        .clean_o (clean)
    );
    assign scl_f = clean[1];
    assign sda_f = clean[0];

    sercfg_events u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_f     (scl_f),
        .sda_f     (sda_f),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    slv_state_t state_q, state_d;
    logic [7:0] shreg_q, shreg_d;
    logic [3:0] cnt_q, cnt_d;
    logic [7:0] idx_q, idx_d;
    logic       rd_q, rd_d;
    logic       mack_q, mack_d;
    logic       wr_en;
    logic       byte_done;

    assign byte_done = scl_fall && (cnt_q == FULL);

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        shreg_d = shreg_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        rd_d    = rd_q;
        mack_d  = mack_q;
        wr_en   = 1'b0;
        if (bus_start) begin
            state_d = ST_ADDR;
            cnt_d   = '0;
        end else if (bus_stop) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: begin
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[6:0], sda_f};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        if (shreg_q[7:1] == DEV_ADDR) begin
                            state_d = ST_ADDR_ACK;
                            rd_d    = shreg_q[0];
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rd_q) begin
                            state_d = ST_TX;
                            shreg_d = status_i;
                        end else begin
                            state_d = ST_SUB;
                        end
                    end
                end
                ST_SUB: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[6:0], sda_f};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_d = ST_SUB_ACK;
                        idx_d   = shreg_q;
                    end
                end
                ST_SUB_ACK, ST_DATA_ACK: begin
                    if (scl_fall) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end
                end
                ST_DATA: begin
                    if (scl_rise) begin
                        shreg_d = {shreg_q[6:0], sda_f};
                        cnt_d   = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_d = ST_DATA_ACK;
                        wr_en   = 1'b1;
                        idx_d   = idx_q + 8'd1;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        cnt_d = cnt_q + 4'd1;
                    end else if (byte_done) begin
                        state_d = ST_TX_ACK;
                        cnt_d   = '0;
                    end else if (scl_fall) begin
                        shreg_d = {shreg_q[6:0], 1'b1};
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_d = !sda_f;
                    end else if (scl_fall) begin
                        if (mack_q) begin
                            state_d = ST_TX;
                            shreg_d = status_i;
                            cnt_d   = '0;
                        end else begin
                            state_d = ST_SKIP;
                        end
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (!enable) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            rd_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            shreg_q <= shreg_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            rd_q    <= rd_d;
            mack_q  <= mack_d;
        end
    end

    // outputs
    always_comb begin
        sda_low_o = 1'b0;
        unique case (state_q)
            ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: sda_low_o = 1'b1;
            ST_TX:                                sda_low_o = !shreg_q[7];
            default:                              sda_low_o = 1'b0;
        endcase
        scl_low_o = 1'b0;
    end

    sercfg_regfile #(.NUM_REGS(NUM_REGS), .REG_DEFAULT(REG_DEFAULT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .wr_en   (wr_en && enable),
        .wr_idx  (idx_q),
        .wr_data (shreg_q),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/sercfg_slave_chk.sv
module sercfg_slave_chk #(
    parameter int         NUM_REGS    = 8,
    parameter logic [7:0] REG_DEFAULT = 8'h40
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  enable,
    input logic                  sda_low_o,
    input logic                  scl_f,
    input logic [NUM_REGS*8-1:0] regs_o
);
    logic [NUM_REGS*8-1:0] dflt;
    logic [NUM_REGS*8-1:0] regs_prev;
    logic [NUM_REGS-1:0]   changed;
    logic                  en_prev;
    logic                  sda_prev;

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            dflt[i*8 +: 8] = REG_DEFAULT + 8'(i);
            changed[i]     = regs_prev[i*8 +: 8] != regs_o[i*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_prev <= dflt;
            en_prev   <= 1'b0;
            sda_prev  <= 1'b0;
        end else begin
            regs_prev <= regs_o;
            en_prev   <= enable;
            sda_prev  <= sda_low_o;
        end
    end

    // R7
    disabled_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !sda_low_o);

    // R7
    disabled_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> regs_o == dflt);

    // R10
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && en_prev) |-> $countones(changed) <= 1);

    // R9
    sda_when_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && en_prev && sda_low_o != sda_prev) |-> !scl_f);

endmodule

bind sercfg_slave sercfg_slave_chk #(
    .NUM_REGS    (NUM_REGS),
    .REG_DEFAULT (REG_DEFAULT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .sda_low_o (sda_low_o),
    .scl_f     (scl_f),
    .regs_o    (regs_o)
);

// File: tb/sercfg_slave_bench.sv
module sercfg_slave_bench;
    localparam int         NR = 8;
    localparam logic [7:0] RD = 8'h40;
    localparam int         PH = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] status = 8'h00;
    logic sda_low, scl_low;
    logic [NR*8-1:0] regs;
    logic scl_ever = 1'b0;

    wire sda_bus = sda_m & ~sda_low;
    wire scl_bus = scl_m & ~scl_low;

    always #5 clk = ~clk;

    sercfg_slave #(.NUM_REGS(NR), .REG_DEFAULT(RD), .DEV_ADDR(7'h46), .FILT_CYCLES(6)) u_sercfg_slave (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .scl_i     (scl_bus),
        .sda_i     (sda_bus),
        .status_i  (status),
        .scl_low_o (scl_low),
        .sda_low_o (sda_low),
        .regs_o    (regs)
    );

    always @(negedge clk) if (scl_low === 1'b1) scl_ever = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [NR];

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bstart();
        sda_m = 1'b1; wt(PH);
        scl_m = 1'b1; wt(PH);
        sda_m = 1'b0; wt(PH);
        scl_m = 1'b0; wt(PH);
    endtask

    task automatic bstop();
        sda_m = 1'b0; wt(PH);
        scl_m = 1'b1; wt(PH);
        sda_m = 1'b1; wt(PH);
    endtask

    task automatic wbit(input logic b);
        sda_m = b;    wt(PH);
        scl_m = 1'b1; wt(PH);
        scl_m = 1'b0; wt(PH);
    endtask

    task automatic rbit(output logic b);
        sda_m = 1'b1; wt(PH);
        scl_m = 1'b1; wt(PH / 2);
        b = sda_bus;  wt(PH / 2);
        scl_m = 1'b0; wt(PH);
    endtask

    // kind 1: short SCL pulse during the low phase; kind 2: short SDA flip during the high phase
    task automatic wbit_glitch(input logic b, input int kind);
        sda_m = b; wt(PH / 2);
        if (kind == 1) begin scl_m = 1'b1; wt(4); scl_m = 1'b0; end
        wt(PH / 2);
        scl_m = 1'b1; wt(PH / 2);
        if (kind == 2) begin sda_m = !b; wt(4); sda_m = b; end
        wt(PH / 2);
        scl_m = 1'b0; wt(PH);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) wbit(v[i]);
        rbit(b);
        ack = !b;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            rbit(b);
            v[i] = b;
        end
        wbit(!give_ack);
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NR; i++) chk(req, 64'(regs[i*8 +: 8]), 64'(model[i]));
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NR; i++) model[i] = RD + 8'(i);
    endtask

    task automatic report();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        report();
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] v;
        logic [7:0] sa, sb;

        model_defaults();
        wt(5);
        rst_n = 1'b1;
        wt(3);
        chk_regs("R8 reset defaults");
        chk("R7 sda released at reset", 64'(sda_low), 64'd0);
        enable = 1'b1;
        wt(PH);

        // R3: burst write of every register from index 0
        bstart();
        wbyte(8'h8C, ack); chk("R1 write address ack", 64'(ack), 64'd1);
        wbyte(8'h00, ack); chk("R3 index ack", 64'(ack), 64'd1);
        for (int i = 0; i < NR; i++) begin
            v = 8'(i * 37 + 11);
            wbyte(v, ack);
            chk("R3 data ack", 64'(ack), 64'd1);
            model[i] = v;
        end
        bstop();
        chk_regs("R3 burst contents");

        // R6: burst running past the last register
        bstart();
        wbyte(8'h8C, ack);
        wbyte(8'(NR - 2), ack);
        for (int i = 0; i < 4; i++) begin
            v = 8'(200 + i * 13);
            wbyte(v, ack);
            chk("R6 ack beyond last", 64'(ack), 64'd1);
            if (NR - 2 + i < NR) model[NR - 2 + i] = v;
        end
        bstop();
        chk_regs("R6 discard beyond last");

        // R4: repeated start changes the index
        bstart();
        wbyte(8'h8C, ack);
        wbyte(8'h02, ack);
        wbyte(8'hA1, ack); model[2] = 8'hA1;
        bstart();
        wbyte(8'h8C, ack); chk("R4 address after repeated start", 64'(ack), 64'd1);
        wbyte(8'h05, ack);
        wbyte(8'hB7, ack); model[5] = 8'hB7;
        wbyte(8'hC3, ack); model[6] = 8'hC3;
        bstop();
        chk_regs("R4 repeated start writes");

        // R1: every single-bit corruption of both addresses is rejected
        for (int b = 1; b < 8; b++) begin
            for (int rw = 0; rw < 2; rw++) begin
                bstart();
                wbyte(8'h8C ^ 8'(rw) ^ (8'h01 << b), ack);
                chk("R1 foreign address nack", 64'(ack), 64'd0);
                wbyte(8'h01, ack);
                chk("R1 ignored after nack", 64'(ack), 64'd0);
                bstop();
            end
        end
        chk_regs("R1 registers untouched");

        // R5: status reads over several values
        for (int k = 0; k < 6; k++) begin
            status = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : 8'(k * 53 + 7);
            bstart();
            wbyte(8'h8D, ack); chk("R1 read address ack", 64'(ack), 64'd1);
            rbyte(v, 1'b0);
            chk("R5 status byte", 64'(v), 64'(status));
            bstop();
        end

        // R5: multi-byte read, status captured per byte, then NAK
        sa = 8'h96; sb = 8'h2D;
        status = sa;
        bstart();
        wbyte(8'h8D, ack);
        status = sb;
        rbyte(v, 1'b1); chk("R5 first byte", 64'(v), 64'(sa));
        rbyte(v, 1'b0); chk("R5 second byte", 64'(v), 64'(sb));
        rbit(ack);
        chk("R5 released after nak", 64'(ack), 64'd1);
        bstop();

        // R11: read after an index write returns status, not register contents
        status = 8'h3C;
        bstart();
        wbyte(8'h8C, ack);
        wbyte(8'h03, ack);
        bstart();
        wbyte(8'h8D, ack);
        rbyte(v, 1'b0);
        chk("R11 read gives status", 64'(v), 64'h3C);
        bstop();
        chk_regs("R11 registers unchanged");

        // R2: short pulses on SCL and SDA inside a data byte
        bstart();
        wbyte(8'h8C, ack);
        wbyte(8'h01, ack);
        v = 8'h5A;
        for (int i = 7; i >= 0; i--) wbit_glitch(v[i], (i == 4) ? 1 : (i == 2) ? 2 : 0);
        rbit(ack);
        chk("R2 ack after glitched byte", 64'(!ack), 64'd1);
        model[1] = 8'h5A;
        bstop();
        chk_regs("R2 glitches rejected");

        // R7: enable drop in the middle of an acknowledge
        bstart();
        for (int i = 7; i >= 0; i--) wbit(v[i] ^ v[i] ^ ((8'h8C >> i) & 1'b1));
        sda_m = 1'b1; wt(PH);
        scl_m = 1'b1; wt(5);
        chk("R7 ack driven before drop", 64'(sda_low), 64'd1);
        enable = 1'b0;
        wt(2);
        chk("R7 sda released", 64'(sda_low), 64'd0);
        model_defaults();
        chk_regs("R7 defaults on disable");
        scl_m = 1'b0; wt(PH);
        bstop();

        // R7: no acknowledge while disabled
        bstart();
        wbyte(8'h8C, ack);
        chk("R7 no ack while disabled", 64'(ack), 64'd0);
        wbyte(8'h00, ack);
        wbyte(8'h77, ack);
        bstop();
        enable = 1'b1;
        wt(PH);
        chk_regs("R7 registers stay default");
        chk("R7 scl never driven", 64'(scl_ever), 64'd0);

        report();
        $finish;
    end

endmodule